// File: doc/BRIEF.md
# Programmable-Period Watchdog Timer

This block supervises a host processor. The host programs a single 8-bit control register with a timeout. The block then counts pulses of a 16 Hz enable that arrives from elsewhere in the chip. If the host does not touch the control register before the count reaches the programmed period, the block raises a sticky timeout flag. It can also drive an interrupt line that it shares with other sources.

The timeout is a 5-bit multiplier times one of four time units: 1/16 s, 1/4 s, 1 s or 4 s. This gives periods from one tick up to 1984 ticks of the 16 Hz enable. Any read or write of the control register starts the period again and clears the flag. A dedicated flag-read strobe also clears the flag. A zero multiplier disables the timer, and so does a register value of zero. The top bit of the register decides whether a timeout reaches the interrupt line.

Top module: `wdog_timer`

## Requirements
- R1: After a synchronous reset the control register reads 8'h00, the flag is 0 and the interrupt is 0.
- R2: The control register returns on `cfg_rdata` the last value written. Its fields are: bit 7 = interrupt-steer bit, bits 6:2 = multiplier, bits 1:0 = time-unit code.
- R3: Unit codes 0, 1, 2 and 3 select 1, 4, 16 and 64 ticks per unit. The flag becomes 1 on the tick that brings the count since the last restart to multiplier × unit. One tick earlier it is still 0. For example, 8'h0E gives 48 ticks.
- R4: A host access (`reg_acc` high, read or write) restarts the count from zero and clears the flag in the following cycle.
- R5: When the multiplier field is zero, whatever the unit code and including 8'h00, ticks never set the flag.
- R6: With the steer bit at 0, `irq` follows the flag. With the steer bit at 1, the flag still sets but `irq` stays 0.
- R7: A pulse on `flag_rd` clears the flag and the interrupt. The register contents are unchanged.
- R8: If a host access and a tick arrive in the same cycle, the access wins and that tick is not counted.
- R9: Once set, the flag stays 1 through further ticks and later periods until a host access or a flag read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse at 16 Hz |
| reg_acc | input | 1 | Host access strobe to the control register |
| reg_wr | input | 1 | When `reg_acc` is high: 1 = write, 0 = read |
| cfg_wdata | input | 8 | Write data for the control register |
| flag_rd | input | 1 | Host read of the flag register, which clears the flag |
| cfg_rdata | output | 8 | Current control register contents |
| wd_flag | output | 1 | Sticky timeout flag |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume each strobe lasts one cycle per event and that `reg_wr` is meaningful only while `reg_acc` is high. They also assume `tick_en` is an isolated pulse, not a level. The stimulus drives every strobe for exactly one clock between falling edges. It separates successive ticks by an idle cycle. It raises an access and a tick together only in the one directed case that checks their priority. Reset is held for several cycles with every strobe low, so the first sampled cycle after reset carries no stale input.

// File: rtl/wdog_pkg.sv
// Package: shared constants and types for the watchdog timer.
// Assumes a 16 Hz tick enable; unit codes scale by powers of four.
package wdog_pkg;
    localparam int DEF_MULT_W    = 5;
    localparam int DEF_UNIT_W    = 2;
    localparam int DEF_UNIT_SHFT = 2;

    // Unit code names, used for readability in the bench and the decode.
    typedef enum logic [DEF_UNIT_W-1:0] {
        UNIT_SIXTEENTH = 2'd0,
        UNIT_QUARTER   = 2'd1,
        UNIT_SECOND    = 2'd2,
        UNIT_FOUR_SEC  = 2'd3
    } unit_code_e;
endpackage

// File: rtl/wdog_cfg_reg.sv
// Module: control register holding steer, multiplier and unit fields.
// Assumes the write strobe lasts one cycle per host write.
module wdog_cfg_reg #(
    parameter int MULT_W = 5,
    parameter int UNIT_W = 2,
    localparam int DATA_W = 1 + MULT_W + UNIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q,
    output logic              steer,
    output logic [MULT_W-1:0] mult,
    output logic [UNIT_W-1:0] unit
);
    // Store the register; clears at reset so the timer starts disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wdata;
        end
    end

    // Split the register into its fields.
    always_comb begin
        steer = cfg_q[DATA_W-1];
        mult  = cfg_q[DATA_W-2:UNIT_W];
        unit  = cfg_q[UNIT_W-1:0];
    end
endmodule

// File: rtl/wdog_period.sv
// Module: turns the multiplier and unit code into a tick count.
// Assumes each unit code is UNIT_SHFT binary orders above the previous one.
module wdog_period #(
    parameter int MULT_W    = 5,
    parameter int UNIT_W    = 2,
    parameter int UNIT_SHFT = 2,
    localparam int N_UNITS  = 1 << UNIT_W,
    localparam int CNT_W    = MULT_W + UNIT_SHFT * (N_UNITS - 1)
) (
    input  logic [MULT_W-1:0] mult,
    input  logic [UNIT_W-1:0] unit,
    output logic [CNT_W-1:0]  period,
    output logic              enabled
);
    logic [CNT_W-1:0] scaled [N_UNITS];

    // One shifted copy of the multiplier per unit code.
    for (genvar g = 0; g < N_UNITS; g++) begin : g_scale
        assign scaled[g] = CNT_W'(mult) << (g * UNIT_SHFT);
    end

    // Pick the copy for the programmed unit; a zero multiplier disables.
    always_comb begin
        period  = scaled[unit];
        enabled = (mult != '0);
    end
endmodule

// File: rtl/wdog_counter.sv
// Module: counts ticks and pulses expire once per full period.
// Assumes period is nonzero whenever enabled is high.
module wdog_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic             enabled,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    // Detect the final tick of a period; a restart masks it.
    always_comb begin
        at_end = (cnt_q == period - CNT_W'(1));
        expire = tick && enabled && !restart && at_end;
    end

    // Advance on ticks, wrap at the period, clear on restart or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enabled) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wdog_timer.sv
// Module: top of the watchdog; register, period decode, counter and flag.
// Assumes strobes are single-cycle and tick_en is a 16 Hz pulse.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int MULT_W    = DEF_MULT_W,
    parameter int UNIT_W    = DEF_UNIT_W,
    parameter int UNIT_SHFT = DEF_UNIT_SHFT,
    localparam int DATA_W   = 1 + MULT_W + UNIT_W,
    localparam int CNT_W    = MULT_W + UNIT_SHFT * ((1 << UNIT_W) - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_acc,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              flag_rd,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              wd_flag,
    output logic              irq
);
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [UNIT_W-1:0] unit;
    logic [CNT_W-1:0]  period;
    logic              enabled;
    logic              expire;
    logic              flag_q;

    wdog_cfg_reg #(.MULT_W(MULT_W), .UNIT_W(UNIT_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_acc && reg_wr),
        .wdata (cfg_wdata),
        .cfg_q (cfg_rdata),
        .steer (steer),
        .mult  (mult),
        .unit  (unit)
    );

    wdog_period #(.MULT_W(MULT_W), .UNIT_W(UNIT_W), .UNIT_SHFT(UNIT_SHFT)) u_per (
        .mult    (mult),
        .unit    (unit),
        .period  (period),
        .enabled (enabled)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (reg_acc),
        .tick    (tick_en),
        .enabled (enabled),
        .period  (period),
        .expire  (expire)
    );

    // Sticky timeout flag: clearing accesses win over a same-cycle expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || reg_acc || flag_rd) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end
    end

    // Route the flag to the interrupt unless it is steered away.
    always_comb begin
        wd_flag = flag_q;
        irq     = flag_q && !steer;
    end
endmodule

// File: rtl/wdog_timer_chk.sv
// Checker: temporal properties on the watchdog ports, bound to the top.
module wdog_timer_chk #(
    parameter int MULT_W  = 5,
    parameter int UNIT_W  = 2,
    localparam int DATA_W = 1 + MULT_W + UNIT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              reg_acc,
    input logic              flag_rd,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              wd_flag,
    input logic              irq
);
    // R1: a reset cycle leaves register and flag clear.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (cfg_rdata == '0 && !wd_flag && !irq));

    // R4: any host access clears the flag next cycle.
    p_access_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_acc |=> !wd_flag);

    // R5: with a zero multiplier a clear flag stays clear.
    p_zero_mult_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[DATA_W-2:UNIT_W] == '0 && !wd_flag) |=> !wd_flag);

    // R6: a steered-away flag never reaches the interrupt.
    p_steer_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[DATA_W-1] |-> !irq);

    // R6: interrupt never appears without the flag.
    p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wd_flag);

    // R7: a flag read clears the flag next cycle.
    p_flag_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd |=> !wd_flag);

    // R3: the flag only rises on the edge that follows a tick.
    p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(tick_en));

    // R9: without a clearing event the flag holds.
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !reg_acc && !flag_rd) |=> wd_flag);
endmodule

bind wdog_timer wdog_timer_chk #(.MULT_W(MULT_W), .UNIT_W(UNIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .reg_acc   (reg_acc),
    .flag_rd   (flag_rd),
    .cfg_rdata (cfg_rdata),
    .wd_flag   (wd_flag),
    .irq       (irq)
);

// File: tb/sim_wdog_timer.sv
// Bench: table-driven period checks, then directed corner cases.
module sim_wdog_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       reg_acc = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       flag_rd = 1'b0;
    logic [7:0] cfg_rdata;
    logic       wd_flag;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_acc   (reg_acc),
        .reg_wr    (reg_wr),
        .cfg_wdata (cfg_wdata),
        .flag_rd   (flag_rd),
        .cfg_rdata (cfg_rdata),
        .wd_flag   (wd_flag),
        .irq       (irq)
    );

    typedef struct packed {
        logic [7:0]  cfg;
        logic [11:0] nticks;
        logic        exp_flag;
        logic        exp_irq;
    } vec_t;

    // R3 R5 R6 period table: value written, ticks applied, expected outputs.
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{8'h04, 12'd1,    1'b1, 1'b1},
        '{8'h08, 12'd1,    1'b0, 1'b0},
        '{8'h08, 12'd2,    1'b1, 1'b1},
        '{8'h05, 12'd3,    1'b0, 1'b0},
        '{8'h05, 12'd4,    1'b1, 1'b1},
        '{8'h06, 12'd15,   1'b0, 1'b0},
        '{8'h06, 12'd16,   1'b1, 1'b1},
        '{8'h07, 12'd63,   1'b0, 1'b0},
        '{8'h07, 12'd64,   1'b1, 1'b1},
        '{8'h0E, 12'd47,   1'b0, 1'b0},
        '{8'h0E, 12'd48,   1'b1, 1'b1},
        '{8'h00, 12'd100,  1'b0, 1'b0},
        '{8'h03, 12'd100,  1'b0, 1'b0},
        '{8'h84, 12'd1,    1'b1, 1'b0},
        '{8'h7F, 12'd1983, 1'b0, 1'b0},
        '{8'hFF, 12'd1984, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] v);
        @(negedge clk);
        reg_acc = 1'b1; reg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk);
        reg_acc = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        reg_acc = 1'b1; reg_wr = 1'b0;
        @(negedge clk);
        reg_acc = 1'b0;
    endtask

    task automatic read_flag();
        @(negedge clk);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reg", cfg_rdata, 8'h00);
        check("R1 flag", {7'd0, wd_flag}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        // R5 disabled straight out of reset
        ticks(20);
        check("R5 reset disabled", {7'd0, wd_flag}, 8'h00);

        // R3 R5 R6 table walk
        for (int k = 0; k < NV; k++) begin
            host_write(VECS[k].cfg);
            ticks(int'(VECS[k].nticks));
            check("R3 table flag", {7'd0, wd_flag}, {7'd0, VECS[k].exp_flag});
            check("R6 table irq", {7'd0, irq}, {7'd0, VECS[k].exp_irq});
        end

        // R2 readback of written fields
        host_write(8'hB6);
        check("R2 readback", cfg_rdata, 8'hB6);

        // R4 read restarts the count and clears the flag
        host_write(8'h08);
        ticks(1);
        host_read();
        ticks(1);
        check("R4 read restart", {7'd0, wd_flag}, 8'h00);
        ticks(1);
        check("R4 expiry after restart", {7'd0, wd_flag}, 8'h01);
        host_read();
        check("R4 read clears", {7'd0, wd_flag}, 8'h00);
        check("R4 read keeps reg", cfg_rdata, 8'h08);

        // R7 flag read clears flag and irq only
        host_write(8'h04);
        ticks(1);
        check("R7 preset irq", {7'd0, irq}, 8'h01);
        read_flag();
        check("R7 flag cleared", {7'd0, wd_flag}, 8'h00);
        check("R7 irq cleared", {7'd0, irq}, 8'h00);
        check("R7 reg unchanged", cfg_rdata, 8'h04);

        // R9 sticky across further periods
        ticks(1);
        ticks(3);
        check("R9 sticky", {7'd0, wd_flag}, 8'h01);

        // R8 access and tick in the same cycle: tick ignored
        @(negedge clk);
        reg_acc = 1'b1; reg_wr = 1'b1; cfg_wdata = 8'h04; tick_en = 1'b1;
        @(negedge clk);
        reg_acc = 1'b0; reg_wr = 1'b0; tick_en = 1'b0;
        check("R8 tick masked", {7'd0, wd_flag}, 8'h00);
        ticks(1);
        check("R8 next tick counts", {7'd0, wd_flag}, 8'h01);

        // R5 writing zero clears and disables
        host_write(8'h00);
        check("R5 zero write clears", {7'd0, wd_flag}, 8'h00);
        ticks(10);
        check("R5 zero stays idle", {7'd0, wd_flag}, 8'h00);

        // R1 reset mid-run returns to defaults
        host_write(8'h04);
        ticks(1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset reg", cfg_rdata, 8'h00);
        check("R1 reset flag", {7'd0, wd_flag}, 8'h00);

        done = 1'b1;
        summary();
    end
endmodule